// File: doc/BRIEF.md
# Idle Link Pulse Generator

This block sits on the transmit side of a 10 Mb/s twisted-pair port. It keeps the link alive while no frames are being sent. When the line has been quiet for a programmable number of milliseconds, it raises a link-pulse request for exactly one bit time. The line driver turns that request into a positive pulse on the wire.

Two clock-enable strobes pace the block, and both are synchronous to `clk`. The bit-time tick arrives once every 100 ns. The millisecond tick arrives once per millisecond. The packet path reports two things: a level that is high while a frame is on the wire, and a one-cycle strobe when a frame's end-of-frame sequence has finished. Either of these restarts the quiet interval. As a result, the first idle pulse comes one full interval after the last frame, and no pulse ever starts during a frame.

Top module: `link_pulse_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `lp_req` is 0. Reset clears the interval count and any pending pulse, so the first pulse needs `INTERVAL_MS` fresh millisecond ticks.
- R2: Count `INTERVAL_MS` millisecond ticks, each sampled with `tx_active` and `eof_done` low. After the last of them, `lp_req` rises one cycle after the first cycle in which `bit_tick` is 1. Until that `bit_tick` comes, `lp_req` stays 0.
- R3: Once high, `lp_req` stays 1 through the next cycle with `bit_tick` = 1 and falls on the cycle after it. The pulse therefore spans exactly one bit time.
- R4: While the port stays idle, successive pulses are spaced by `INTERVAL_MS` millisecond ticks. The count restarts at the tick that ends each interval.
- R5: An `eof_done` strobe clears the interval count. A millisecond tick in the same cycle as `eof_done` is not counted, so the next pulse needs `INTERVAL_MS` further ticks.
- R6: No pulse starts in the cycle after one with `tx_active` = 1. While `tx_active` is 1, the count is held at zero, so after transmission ends a full interval is needed again.
- R7: A pulse that has already started runs to its full bit time, even if `tx_active` or `eof_done` is asserted during it.
- R8: Suppose an interval has ended but its pulse has not started yet. If `tx_active` or `eof_done` arrives in that gap, the pending pulse is dropped and no pulse follows the next `bit_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per 100 ns bit time |
| ms_tick | input | 1 | One-cycle strobe per millisecond |
| tx_active | input | 1 | High while a frame is being transmitted |
| eof_done | input | 1 | One-cycle strobe when an end-of-frame sequence completes |
| lp_req | output | 1 | Link pulse request, high for one bit time |

## Verification
The bench aims at the places where the interval can restart and where a pulse can be cut short.

- **End-of-frame on a tick.** It strobes end-of-frame in the same cycle as a millisecond tick. A design that still counted that tick would pulse one millisecond early.
- **Transmit spanning interval ends.** It holds transmit high across several interval ends. A design that carried the count through would pulse too soon after the frame.
- **Transmit or end-of-frame during a pulse.** It raises either one mid-pulse. A design that aborted the pulse would emit a truncated one.
- **Cancel in the gap.** It cancels a pending pulse in the gap between interval end and the next bit tick. A design that ignored the cancel would start a pulse right after traffic.
- **Reset with a pulse armed.** It resets with a pulse pending. The pending pulse must not survive the reset.

// File: rtl/link_pulse_gen.sv
module link_pulse_gen #(
  parameter int INTERVAL_MS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic ms_tick,
  input  logic tx_active,
  input  logic eof_done,
  output logic lp_req
);
  localparam int CW = $clog2(INTERVAL_MS + 1);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL_MS - 1);

  logic [CW-1:0] ms_cnt;
  logic          armed;

  // traffic restarts the quiet interval and drops any pending pulse
  wire restart = tx_active | eof_done;
  wire expire  = ms_tick & ~restart & (ms_cnt == LAST);
  wire start   = armed & bit_tick & ~restart & ~lp_req;

  always_ff @(posedge clk) begin
    if (!rst_n)                 ms_cnt <= '0;
    else if (restart || expire) ms_cnt <= '0;
    else if (ms_tick)           ms_cnt <= ms_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       armed <= 1'b0;
    else if (restart) armed <= 1'b0;
    else if (expire)  armed <= 1'b1;
    else if (start)   armed <= 1'b0;
  end

  // a started pulse ends only on the next bit boundary
  always_ff @(posedge clk) begin
    if (!rst_n)                 lp_req <= 1'b0;
    else if (lp_req && bit_tick) lp_req <= 1'b0;
    else if (start)             lp_req <= 1'b1;
  end
endmodule

// File: rtl/link_pulse_gen_chk.sv
module link_pulse_gen_chk #(
  parameter int INTERVAL_MS = 16
) (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic ms_tick,
  input logic tx_active,
  input logic eof_done,
  input logic lp_req
);
  localparam int GW = $clog2(INTERVAL_MS + 1) + 1;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n || tx_active || eof_done) gap <= '0;
    else if (ms_tick && gap < GW'(INTERVAL_MS)) gap <= gap + 1'b1;
  end

  // R3
  rise_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lp_req) |-> $past(bit_tick));
  // R3
  fall_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lp_req) |-> $past(bit_tick));
  // R7
  hold_until_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_req && !bit_tick) |=> lp_req);
  // R6
  no_start_in_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lp_req) |-> !$past(tx_active));
  // R5
  full_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lp_req) |-> (gap >= GW'(INTERVAL_MS)));
endmodule

bind link_pulse_gen link_pulse_gen_chk #(.INTERVAL_MS(INTERVAL_MS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ms_tick(ms_tick),
  .tx_active(tx_active), .eof_done(eof_done), .lp_req(lp_req)
);

// File: tb/tb_link_pulse_gen.sv
module tb_link_pulse_gen;
  localparam int CLK_PERIOD = 10;
  localparam int IV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, ms_tick = 1'b0, tx_active = 1'b0, eof_done = 1'b0;
  logic lp_req;
  logic txv = 1'b0;

  int cyc = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur_tag = "R1";

  int    q_cyc[$];
  bit    q_rise[$];
  string q_tag[$];

  link_pulse_gen #(.INTERVAL_MS(IV)) dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ms_tick(ms_tick),
    .tx_active(tx_active), .eof_done(eof_done), .lp_req(lp_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: every edge of lp_req must match the head of the queue
  logic prev = 1'b0;
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (!rst_n) prev = 1'b0;
    else if (lp_req !== prev) begin
      n_chk++;
      if (q_cyc.size() == 0) begin
        n_bad++;
        $display("FAIL %s: unexpected lp_req edge to %b at cycle %0d, expected none", cur_tag, lp_req, cyc);
      end else begin
        automatic int ec = q_cyc.pop_front();
        automatic bit er = q_rise.pop_front();
        automatic string et = q_tag.pop_front();
        if (ec != cyc || er != lp_req) begin
          n_bad++;
          $display("FAIL %s: lp_req=%b at cycle %0d, expected %b at cycle %0d", et, lp_req, cyc, er, ec);
        end
      end
      prev = lp_req;
    end
  end

  task automatic drive(input logic bt, input logic mt, input logic eof);
    @(negedge clk);
    bit_tick = bt; ms_tick = mt; eof_done = eof; tx_active = txv;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0);
  endtask

  task automatic ms(input int n);
    for (int i = 0; i < n; i++) begin
      drive(1'b0, 1'b1, 1'b0);
      idle(2);
    end
  endtask

  task automatic bit_edge(input bit rise, input string tag);
    drive(1'b1, 1'b0, 1'b0);
    q_cyc.push_back(cyc + 1); q_rise.push_back(rise); q_tag.push_back(tag);
    idle(3);
  endtask

  task automatic bit_none(input string tag);
    drive(1'b1, 1'b0, 1'b0);
    @(posedge clk); #(CLK_PERIOD/4);
    n_chk++;
    if (lp_req !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: lp_req=%b after bit tick, expected 0", tag, lp_req);
    end
    idle(2);
  endtask

  task automatic pulse(input string tag);
    bit_edge(1'b1, tag);
    bit_edge(1'b0, "R3");
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R2: watchdog expired, expected run to finish");
    finish_run();
  end

  initial begin
    idle(3);
    n_chk++;
    if (lp_req !== 1'b0) begin
      n_bad++; $display("FAIL R1: lp_req=%b in reset, expected 0", lp_req);
    end
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #(CLK_PERIOD/4);
    n_chk++;
    if (lp_req !== 1'b0) begin
      n_bad++; $display("FAIL R1: lp_req=%b after reset, expected 0", lp_req);
    end

    // R1 / R2: full interval after reset, pulse waits for bit tick
    cur_tag = "R1";
    ms(IV - 1); bit_none("R1");
    cur_tag = "R2";
    ms(1); idle(5); pulse("R2");

    // R4: periodic pulses
    cur_tag = "R4";
    ms(IV); pulse("R4");
    ms(IV); idle(1); pulse("R4");

    // R5: end-of-frame restart, including a tick in the same cycle
    cur_tag = "R5";
    ms(2); drive(1'b0, 1'b0, 1'b1); ms(IV - 1); bit_none("R5");
    ms(1); pulse("R5");
    ms(3); drive(1'b0, 1'b1, 1'b1); ms(IV - 1); bit_none("R5");
    ms(1); pulse("R5");

    // R6: transmit across interval ends holds the count
    cur_tag = "R6";
    ms(2); txv = 1'b1; ms(2 * IV); bit_none("R6"); txv = 1'b0;
    ms(IV - 1); bit_none("R6");
    ms(1); pulse("R6");

    // R7: pulse completes under transmit and end-of-frame
    cur_tag = "R7";
    ms(IV); bit_edge(1'b1, "R7"); txv = 1'b1; idle(2); bit_edge(1'b0, "R7"); txv = 1'b0;
    ms(IV); bit_edge(1'b1, "R7"); drive(1'b0, 1'b0, 1'b1); idle(1); bit_edge(1'b0, "R7");

    // R8: pending pulse cancelled
    cur_tag = "R8";
    ms(IV); txv = 1'b1; idle(1); txv = 1'b0; bit_none("R8");
    ms(IV); pulse("R8");
    ms(IV); drive(1'b0, 1'b0, 1'b1); bit_none("R8");
    ms(IV - 1); bit_none("R8");
    ms(1); pulse("R8");

    // R1: reset with a pulse pending and mid-count
    cur_tag = "R1";
    ms(IV); @(negedge clk); rst_n = 1'b0; idle(2);
    @(negedge clk); rst_n = 1'b1; bit_none("R1");
    ms(2); @(negedge clk); rst_n = 1'b0; idle(1); @(negedge clk); rst_n = 1'b1;
    ms(IV - 1); bit_none("R1");
    ms(1); pulse("R1");

    idle(10);
    while (q_cyc.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL %s: lp_req edge missing, expected %b at cycle %0d", q_tag[0], q_rise[0], q_cyc[0]);
      void'(q_cyc.pop_front()); void'(q_rise.pop_front()); void'(q_tag.pop_front());
    end
    finish_run();
  end
endmodule